// File: doc/BRIEF.md
# Text Overlay Character Raster Timing Generator

This block produces the raster timing for a text overlay made of 24 columns by 12 rows of character cells. Each cell is 12 pixels wide and 18 pixels high. It counts dot-clock enables after each line strobe and line strobes after each field strobe. From these counts it works out which cell and which glyph pixel the beam is over. Each pixel can be stretched by 1, 2 or 3 dot clocks across and by 1, 2 or 3 lines down. The first text row has its own stretch codes. All later rows share a second pair of codes.

The block reads the display memory one cell ahead, so that a memory with one cycle of read latency has the next character code ready when the beam reaches that cell. It outputs the glyph row and glyph column to drive an external character ROM. It also gives per-pixel show and invert qualifiers for blinking and reverse video, a flag for the blanking region, and a blink phase counted in fields.

The block is raster-locked, so no output can stall. Every output is plain level data, valid in each cycle where `dot_en` is high, and there is no back-pressure.

Top module: `osd_raster_gen`

## Requirements
- R1: After reset, and until the first strobe, `in_cell`, `char_show`, `pix_invert` and `blink_phase` are 0, and both display-memory address outputs are 0.
- R2: The grid is 24 columns by 12 rows. Within a cell, `glyph_col` runs from 0 to 11 and `glyph_row` runs from 0 to 17, and each value holds for the stretch width or height. `in_cell` is 1 exactly on the pixels of the active grid.
- R3: The 2-bit width code maps 00 to 1 dot clock per pixel, 01 to 2, 10 to 3 and 11 to 1.
- R4: The 2-bit height code uses the same mapping as the width code, counted in lines per pixel.
- R5: Row 0 uses `wcode_first` and `hcode_first`. Every later row uses `wcode_rest` and `hcode_rest`.
- R6: Lines are numbered from 0, and line 0 starts at the first `hsync` after a `vsync`. Row 0 starts on line 2·`v_start`.
- R7: Dots are numbered from 0, and dot 0 is the first `dot_en` cycle after `hsync`. Column 0 starts on dot 2·`h_start`.
- R8: While the beam is in column c of an active row, `vram_col` is (c+1) mod 24. On that line, before column 0 and after column 23, `vram_col` is 0. `vram_row` is the current row.
- R9: When `ten_rows` is 1 the grid ends after row 9. When it is 0 the grid ends after row 11.
- R10: `blink_phase` starts at 0. It toggles on every BLINK_FIELDS-th `vsync` when `blink_slow` is 0, and on every 2·BLINK_FIELDS-th `vsync` when `blink_slow` is 1.
- R11: `char_show` is 1 in a cell unless blinking is on, `blink_phase` is 1 and `reverse_en` is 0. `pix_invert` is 1 on shown pixels when `reverse_en` is 1, except when blinking is on and `blink_phase` is 1. In that case reverse characters alternate between inverse and normal.
- R12: `blank_sel` sets `blank_area`: 00 gives always 0, 01 follows `in_cell`, 10 covers every line of the active rows, and 11 gives always 1.
- R13: With `disp_on` at 0, `char_show` and `pix_invert` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dot_en | input | 1 | One pixel dot per high cycle |
| hsync | input | 1 | Line start strobe |
| vsync | input | 1 | Field start strobe |
| h_start | input | 6 | Horizontal start, units of 2 dots |
| v_start | input | 6 | Vertical start, units of 2 lines |
| wcode_first | input | 2 | Width code of row 0 |
| wcode_rest | input | 2 | Width code of rows 1 and up |
| hcode_first | input | 2 | Height code of row 0 |
| hcode_rest | input | 2 | Height code of rows 1 and up |
| disp_on | input | 1 | Character output enable |
| reverse_en | input | 1 | Reverse video |
| blink_en | input | 1 | Blink enable |
| blink_slow | input | 1 | 1 selects the doubled blink period |
| blank_sel | input | 2 | Blanking region select |
| ten_rows | input | 1 | 1 limits the grid to 10 rows |
| in_cell | output | 1 | Pixel is inside the active grid |
| vram_row | output | 4 | Display-memory row address |
| vram_col | output | 5 | Display-memory column address, one cell ahead |
| glyph_row | output | 5 | Glyph line index for the character ROM |
| glyph_col | output | 4 | Glyph pixel index for the character ROM |
| char_show | output | 1 | Character pixel may be drawn |
| pix_invert | output | 1 | Draw the pixel inverted |
| blank_area | output | 1 | Pixel lies in the blanking region |
| blink_phase | output | 1 | Current blink phase |

## Verification
Full lines are compared dot by dot against an arithmetic model under four patterns:
- unit stretch with non-zero start offsets, which separates errors in the start scaling from errors in the cell counting;
- mixed stretch codes with a different first row, which exposes a scale decoded wrongly or applied to the wrong row;
- code 11 on all axes, which checks the alias to a stretch of 1;
- the ten-row limit, checked at the line where the grid should end.

The sampled lines sit around row boundaries and the grid's bottom edge. Blink phase is followed across long strings of field strobes in both period settings, and show and invert are compared with blinking and reverse video each set both ways.

// File: rtl/osd_pkg.sv
package osd_pkg;

  typedef enum logic [1:0] {
    BLANK_NONE = 2'd0,
    BLANK_CELL = 2'd1,
    BLANK_BAND = 2'd2,
    BLANK_FULL = 2'd3
  } blank_mode_e;

  // Stretch factor for a 2-bit size code; the spare code aliases to 1.
  function automatic logic [1:0] pix_scale(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/osd_axis_scan.sv
module osd_axis_scan #(
  parameter int UNITS = 24,
  parameter int SUBS  = 12,
  parameter int POS_W = 6,
  parameter bit LEAD  = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       step,
  input  logic [POS_W:0]             start,
  input  logic [1:0]                 scale,
  input  logic [$clog2(UNITS)-1:0]   last_unit,
  output logic                       on,
  output logic [$clog2(UNITS)-1:0]   unit,
  output logic [$clog2(SUBS)-1:0]    pix
);
  localparam int UW = $clog2(UNITS);
  localparam int SW = $clog2(SUBS);
  localparam int CW = POS_W + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt;
  logic [1:0]    sub;
  logic          lead;
  logic          done;
  logic          at_start;

  assign at_start = ({1'b0, cnt} + 1'b1) == {1'b0, start};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sub  <= '0;
      pix  <= '0;
      unit <= '0;
      on   <= 1'b0;
      done <= 1'b0;
      lead <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      sub  <= '0;
      pix  <= '0;
      unit <= '0;
      done <= 1'b0;
      lead <= LEAD;
      on   <= LEAD ? 1'b0 : (start == '0);
    end else if (step) begin
      if (lead) begin
        lead <= 1'b0;
        on   <= (start == '0);
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (on) begin
          if (sub >= scale - 2'd1) begin
            sub <= '0;
            if (pix == SW'(SUBS - 1)) begin
              pix <= '0;
              if (unit >= last_unit) begin
                on   <= 1'b0;
                done <= 1'b1;
              end else begin
                unit <= unit + 1'b1;
              end
            end else begin
              pix <= pix + 1'b1;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end else if (!done && at_start) begin
          on <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter int FIELDS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic slow,
  output logic phase
);
  localparam int CW = $clog2(2 * FIELDS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = slow ? CW'(2 * FIELDS - 1) : CW'(FIELDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (vsync) begin
      if (cnt >= limit) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/osd_raster_gen.sv
module osd_raster_gen #(
  parameter int COLS         = 24,
  parameter int ROWS         = 12,
  parameter int ROWS_SHORT   = 10,
  parameter int CELL_W       = 12,
  parameter int CELL_H       = 18,
  parameter int POS_W        = 6,
  parameter int BLINK_FIELDS = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dot_en,
  input  logic                        hsync,
  input  logic                        vsync,
  input  logic [POS_W-1:0]            h_start,
  input  logic [POS_W-1:0]            v_start,
  input  logic [1:0]                  wcode_first,
  input  logic [1:0]                  wcode_rest,
  input  logic [1:0]                  hcode_first,
  input  logic [1:0]                  hcode_rest,
  input  logic                        disp_on,
  input  logic                        reverse_en,
  input  logic                        blink_en,
  input  logic                        blink_slow,
  input  logic [1:0]                  blank_sel,
  input  logic                        ten_rows,
  output logic                        in_cell,
  output logic [$clog2(ROWS)-1:0]     vram_row,
  output logic [$clog2(COLS)-1:0]     vram_col,
  output logic [$clog2(CELL_H)-1:0]   glyph_row,
  output logic [$clog2(CELL_W)-1:0]   glyph_col,
  output logic                        char_show,
  output logic                        pix_invert,
  output logic                        blank_area,
  output logic                        blink_phase
);
  import osd_pkg::*;

  localparam int RW  = $clog2(ROWS);
  localparam int CLW = $clog2(COLS);

  logic           v_on, h_on;
  logic [RW-1:0]  row;
  logic [CLW-1:0] col;
  logic           first_row;
  logic [1:0]     v_scale, h_scale;
  logic [RW-1:0]  row_last;
  logic           blink_dark;
  blank_mode_e    blank_mode;

  assign first_row = (row == '0);
  assign v_scale   = pix_scale(first_row ? hcode_first : hcode_rest);
  assign h_scale   = pix_scale(first_row ? wcode_first : wcode_rest);
  assign row_last  = ten_rows ? RW'(ROWS_SHORT - 1) : RW'(ROWS - 1);

  osd_axis_scan #(
    .UNITS(ROWS), .SUBS(CELL_H), .POS_W(POS_W), .LEAD(1'b1)
  ) u_vscan (
    .clk(clk), .rst_n(rst_n), .restart(vsync), .step(hsync),
    .start({v_start, 1'b0}), .scale(v_scale), .last_unit(row_last),
    .on(v_on), .unit(row), .pix(glyph_row)
  );

  osd_axis_scan #(
    .UNITS(COLS), .SUBS(CELL_W), .POS_W(POS_W), .LEAD(1'b0)
  ) u_hscan (
    .clk(clk), .rst_n(rst_n), .restart(hsync), .step(dot_en),
    .start({h_start, 1'b0}), .scale(h_scale), .last_unit(CLW'(COLS - 1)),
    .on(h_on), .unit(col), .pix(glyph_col)
  );

  osd_blink_timer #(
    .FIELDS(BLINK_FIELDS)
  ) u_blink (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .slow(blink_slow),
    .phase(blink_phase)
  );

  assign in_cell  = v_on && h_on;
  assign vram_row = v_on ? row : '0;
  assign vram_col = !h_on ? '0 : (col == CLW'(COLS - 1)) ? '0 : col + 1'b1;

  assign blink_dark = blink_en && blink_phase;
  assign char_show  = disp_on && in_cell && !(blink_dark && !reverse_en);
  assign pix_invert = char_show && reverse_en && !blink_dark;

  assign blank_mode = blank_mode_e'(blank_sel);
  always_comb begin
    case (blank_mode)
      BLANK_CELL: blank_area = in_cell;
      BLANK_BAND: blank_area = v_on;
      BLANK_FULL: blank_area = 1'b1;
      default:    blank_area = 1'b0;
    endcase
  end

endmodule

// File: rtl/osd_raster_chk.sv
module osd_raster_chk #(
  parameter int COLS       = 24,
  parameter int ROWS       = 12,
  parameter int ROWS_SHORT = 10,
  parameter int CELL_W     = 12,
  parameter int CELL_H     = 18
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        vsync,
  input logic                        disp_on,
  input logic                        ten_rows,
  input logic [1:0]                  blank_sel,
  input logic                        in_cell,
  input logic [$clog2(ROWS)-1:0]     vram_row,
  input logic [$clog2(COLS)-1:0]     vram_col,
  input logic [$clog2(CELL_H)-1:0]   glyph_row,
  input logic [$clog2(CELL_W)-1:0]   glyph_col,
  input logic                        char_show,
  input logic                        pix_invert,
  input logic                        blank_area,
  input logic                        blink_phase
);

  AST_GLYPH_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_cell |-> int'(glyph_col) < CELL_W); // R2
  AST_GLYPH_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_cell |-> int'(glyph_row) < CELL_H); // R2
  AST_VRAM_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vram_col) < COLS); // R8
  AST_TEN_ROW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cell && ten_rows) |-> int'(vram_row) < ROWS_SHORT); // R9
  AST_BLINK_ON_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(blink_phase)); // R10
  AST_SHOW_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    char_show |-> in_cell); // R11
  AST_INVERT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_invert |-> char_show); // R11
  AST_BLANK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_sel == 2'd0) |-> !blank_area); // R12
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (!char_show && !pix_invert)); // R13

endmodule

bind osd_raster_gen osd_raster_chk #(
  .COLS(COLS), .ROWS(ROWS), .ROWS_SHORT(ROWS_SHORT),
  .CELL_W(CELL_W), .CELL_H(CELL_H)
) u_chk (.*);

// File: tb/osd_raster_gen_test.sv
`timescale 1ns/1ps
module osd_raster_gen_test;
  localparam int BF = 15;
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dot_en = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [5:0] h_start = '0, v_start = '0;
  logic [1:0] wf = '0, wr = '0, hf = '0, hr = '0, blank_sel = '0;
  logic disp_on = 1'b0, reverse_en = 1'b0, blink_en = 1'b0, blink_slow = 1'b0, ten_rows = 1'b0;

  logic       in_cell, char_show, pix_invert, blank_area, blink_phase;
  logic [3:0] vram_row;
  logic [4:0] vram_col;
  logic [4:0] glyph_row;
  logic [3:0] glyph_col;

  always #2 clk = ~clk;

  osd_raster_gen uut (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .hsync(hsync), .vsync(vsync),
    .h_start(h_start), .v_start(v_start),
    .wcode_first(wf), .wcode_rest(wr), .hcode_first(hf), .hcode_rest(hr),
    .disp_on(disp_on), .reverse_en(reverse_en), .blink_en(blink_en),
    .blink_slow(blink_slow), .blank_sel(blank_sel), .ten_rows(ten_rows),
    .in_cell(in_cell), .vram_row(vram_row), .vram_col(vram_col),
    .glyph_row(glyph_row), .glyph_col(glyph_col), .char_show(char_show),
    .pix_invert(pix_invert), .blank_area(blank_area), .blink_phase(blink_phase)
  );

  typedef struct {
    bit in_cell; bit vact; bit show; bit inv; bit blank;
    int vrow; int vcol; int grow; int gcol;
  } exp_t;

  exp_t q[$];
  logic mon_en = 1'b0;
  int checks = 0;
  int errors = 0;
  int bl_cnt = 0;
  bit bl_phase = 1'b0;

  function automatic int dec(logic [1:0] c);
    return (c == 2'd1) ? 2 : (c == 2'd2) ? 3 : 1;
  endfunction

  // Expected outputs for dot 'dot' of line 'line', from R2-R9, R11-R13.
  function automatic exp_t model(int line, int dot);
    exp_t e;
    int vst, rel, row, w, hst, col, h0, hn;
    bit hact;
    e = '{default: 0};
    row = 0;
    vst = 2 * int'(v_start);
    if (line >= vst) begin
      rel = line - vst;
      h0 = dec(hf);
      if (rel < 18 * h0) begin
        e.vact = 1; e.grow = rel / h0;
      end else begin
        rel = rel - 18 * h0;
        hn = dec(hr);
        row = 1 + rel / (18 * hn);
        e.grow = (rel % (18 * hn)) / hn;
        e.vact = (row < (ten_rows ? 10 : 12));
      end
    end
    e.vrow = row;
    w = (row == 0) ? dec(wf) : dec(wr);
    hst = 2 * int'(h_start);
    hact = 0;
    col = 0;
    if (dot >= hst) begin
      rel = dot - hst;
      col = rel / (12 * w);
      if (col < 24) begin
        hact = 1; e.gcol = (rel % (12 * w)) / w;
      end
    end
    e.vcol = hact ? (col + 1) % 24 : 0;
    e.in_cell = e.vact && hact;
    e.show = disp_on && e.in_cell && !(blink_en && bl_phase && !reverse_en);
    e.inv = e.show && reverse_en && !(blink_en && bl_phase);
    case (blank_sel)
      2'd1: e.blank = e.in_cell;
      2'd2: e.blank = e.vact;
      2'd3: e.blank = 1;
      default: e.blank = 0;
    endcase
    return e;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares as dots are produced.
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (mon_en) begin
      if (q.size() == 0) begin
        chk("R2 scoreboard underflow", 0, 1);
      end else begin
        e = q.pop_front();
        chk("R2 in_cell", int'(in_cell), int'(e.in_cell));
        if (e.in_cell) begin
          chk("R2 glyph_row", int'(glyph_row), e.grow);
          chk("R2 glyph_col", int'(glyph_col), e.gcol);
        end
        if (e.vact) begin
          chk("R8 vram_row", int'(vram_row), e.vrow);
          chk("R8 vram_col", int'(vram_col), e.vcol);
        end
        chk("R11 char_show", int'(char_show), int'(e.show));
        chk("R11 pix_invert", int'(pix_invert), int'(e.inv));
        chk("R12 blank_area", int'(blank_area), int'(e.blank));
      end
    end
  end

  task automatic pulse_vsync();
    @(negedge clk);
    vsync = 1'b1;
    if (bl_cnt >= (blink_slow ? 2 * BF : BF) - 1) begin
      bl_cnt = 0; bl_phase = !bl_phase;
    end else begin
      bl_cnt++;
    end
    @(negedge clk);
    vsync = 1'b0;
  endtask

  // Driver: one field; lines near b0/b1 and a sparse sample are fully checked.
  task automatic frame(int nlines, int b0, int b1);
    int full;
    bit sel;
    full = 2 * int'(h_start) + 24 * 12 * ((dec(wf) > dec(wr)) ? dec(wf) : dec(wr)) + 3;
    pulse_vsync();
    for (int line = 0; line < nlines; line++) begin
      sel = (line < 6) || (line % 29 == 0) ||
            (line >= b0 - 2 && line <= b0 + 2) || (line >= b1 - 2 && line <= b1 + 2);
      @(negedge clk);
      hsync = 1'b1;
      @(negedge clk);
      hsync = 1'b0;
      for (int d = 0; d < (sel ? full : 2); d++) begin
        dot_en = 1'b1;
        mon_en = sel;
        if (sel) q.push_back(model(line, d));
        @(negedge clk);
      end
      dot_en = 1'b0;
      mon_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk("R1 in_cell", int'(in_cell), 0);
    chk("R1 blink_phase", int'(blink_phase), 0);
    chk("R1 vram_row", int'(vram_row), 0);
    chk("R1 vram_col", int'(vram_col), 0);
    chk("R1 char_show", int'(char_show), 0);
    chk("R1 pix_invert", int'(pix_invert), 0);

    // R6 R7 R2 R8: unit stretch, offset start, 12 rows, cell blanking
    disp_on = 1; v_start = 6'd2; h_start = 6'd3; blank_sel = 2'd1;
    frame(225, 22, 220);

    // R3 R4 R5 R9: mixed codes, own first-row codes, 10 rows, band blanking
    v_start = 0; h_start = 0; wf = 2'b01; hf = 2'b10; wr = 2'b10; hr = 2'b01;
    ten_rows = 1; blank_sel = 2'd2;
    frame(383, 54, 378);

    // R3 R4: code 11 aliases to 1; R12 full blanking; R11 reverse steady
    ten_rows = 0; v_start = 6'd1; h_start = 6'd5;
    wf = 2'b11; hf = 2'b11; wr = 2'b11; hr = 2'b11; blank_sel = 2'd3; reverse_en = 1;
    frame(40, 20, 38);

    // R13: display off hides everything
    disp_on = 0; blank_sel = 2'd0;
    frame(24, 0, 0);

    // R10: fast blink period
    disp_on = 1; reverse_en = 0; blink_en = 1; h_start = 0; v_start = 0;
    wf = 0; wr = 0; hf = 0; hr = 0;
    for (int i = 0; i < 40; i++) begin
      pulse_vsync();
      chk("R10 blink_phase fast", int'(blink_phase), int'(bl_phase));
    end
    while (!bl_phase) pulse_vsync();
    // R11: blink phase 1 hides normal characters
    frame(8, 0, 0);
    // R11: reverse characters shown, non-inverted in phase 1
    reverse_en = 1;
    frame(8, 0, 0);
    while (bl_phase) pulse_vsync();
    // R11: reverse characters inverted in phase 0
    frame(8, 0, 0);

    // R10: slow blink period
    blink_slow = 1;
    for (int i = 0; i < 70; i++) begin
      pulse_vsync();
      chk("R10 blink_phase slow", int'(blink_phase), int'(bl_phase));
    end
    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", q.size(), 0);
    finish_run();
  end

endmodule